// File: doc/BRIEF.md
# Battery Thermistor Zone Monitor

This block takes a digitized reading of a battery-pack thermistor pin and sorts it into one of five operating zones: disabled (pin pulled low), hot, normal, cold, and charger-only. In charger-only mode the pin is floating or pulled high, the safety timer is held and termination is off. Each zone boundary has its own hysteresis. A committed zone changes only after the new classification has held for a deglitch window counted in 1 ms ticks. From the committed zone the block derives a charge-enable flag, a timer-hold flag, a termination-disable flag, a one-clock new-cycle pulse and a select for the thermistor bias current.

Voltage codes arrive on a valid/ready stream in unsigned millivolts. The block never applies back-pressure: `smp_ready` is always high, and a code is taken on every clock where `smp_valid` is high. Between accepted samples the last code is held.

The block comes out of reset in the disabled zone. Charge therefore stays off until a valid pin reading has been held for a full deglitch window.

Top module: `ts_zone_monitor`

## Requirements
- R1: After reset the outputs are as follows. `zone_o` is 0 (disabled), `chg_en_o`, `tmr_hold_o`, `term_dis_o` and `new_cycle_o` are 0, `bias_sel_o` is 2 (disable level) and `smp_ready` is 1.
- R2: The disabled zone (code 0) is chosen when the held sample is below 76 mV. From the disabled zone the sample must reach 88 mV or more before another zone is chosen.
- R3: The hot zone (code 1) is chosen below 275 mV. From the hot zone the sample must reach 295 mV or more to leave it.
- R4: The cold zone (code 3) is chosen above 1250 mV. From the cold zone the sample must fall to 1150 mV or less to leave it.
- R5: The charger-only zone (code 4) is chosen above 1600 mV. From it the sample must fall to 1500 mV or less to leave it. Normal is code 2. The priority order is disabled, then charger-only, then hot, then cold, then normal.
- R6: Every zone change is deglitched. The zone changes on the clock of the Nth tick for which the new classification has been constant. N is 30 when the charger-only zone is on either side of the change, and 30 otherwise (these are separate parameters). If the classification returns to the current zone or moves to a different target, the count restarts. The zone never changes on a clock without a tick.
- R7: `chg_en_o` is 1 in the normal and charger-only zones. `tmr_hold_o` and `term_dis_o` are 1 only in the charger-only zone.
- R8: `new_cycle_o` is high for exactly one clock, on the clock the zone commits away from the disabled or the charger-only zone. It is high at no other time.
- R9: `bias_sel_o` is 2 in the disabled zone. In any other zone it is 1 (fold-back) when the held sample is 1475 mV or more, and 0 (normal) otherwise.
- R10: A code on `smp_mv` has no effect unless `smp_valid` is high. `smp_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-clock pulse every millisecond |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, always 1 |
| smp_mv | input | CODE_W (12) | Pin voltage in millivolts |
| zone_o | output | 3 | Committed zone: 0 disabled, 1 hot, 2 normal, 3 cold, 4 charger-only |
| chg_en_o | output | 1 | Charging permitted |
| tmr_hold_o | output | 1 | Safety timer held in reset |
| term_dis_o | output | 1 | Termination disabled |
| new_cycle_o | output | 1 | One-clock pulse to start a new charge cycle |
| bias_sel_o | output | 2 | Bias current: 0 normal, 1 fold-back, 2 disable level |

## Verification
Some properties are checked on every cycle:
- the zone changes only on a tick;
- the new-cycle pulse lasts one clock and follows only a commit out of the disabled or charger-only zone;
- the timer-hold and termination-disable flags agree;
- the held sample is stable while no sample is valid.

The hysteresis edges need stimulus and can only be shown by the bench's scenarios. Those scenarios hold values one millivolt on each side of every threshold, count exactly N ticks, interrupt a deglitch with a short excursion, and apply random voltage and hold-time pairs against a reference model.

// File: rtl/ts_zone_pkg.sv
package ts_zone_pkg;
  typedef enum logic [2:0] {
    ZN_DIS  = 3'd0,
    ZN_HOT  = 3'd1,
    ZN_NORM = 3'd2,
    ZN_COLD = 3'd3,
    ZN_ONLY = 3'd4
  } zone_t;

  typedef enum logic [1:0] {
    BS_NORM = 2'd0,
    BS_FOLD = 2'd1,
    BS_DIS  = 2'd2
  } bias_t;
endpackage

// File: rtl/ts_zone_classify.sv
module ts_zone_classify
  import ts_zone_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int EN_MV       = 88,
  parameter int EN_HYS_MV   = 12,
  parameter int HOT_MV      = 275,
  parameter int HOT_HYS_MV  = 20,
  parameter int COLD_MV     = 1250,
  parameter int COLD_HYS_MV = 100,
  parameter int ONLY_MV     = 1600,
  parameter int ONLY_HYS_MV = 100
) (
  input  zone_t             zone_i,
  input  logic [CODE_W-1:0] mv_i,
  output zone_t             cand_o
);
  localparam logic [CODE_W-1:0] EN_HI   = CODE_W'(EN_MV);
  localparam logic [CODE_W-1:0] EN_LO   = CODE_W'(EN_MV - EN_HYS_MV);
  localparam logic [CODE_W-1:0] HOT_LO  = CODE_W'(HOT_MV);
  localparam logic [CODE_W-1:0] HOT_HI  = CODE_W'(HOT_MV + HOT_HYS_MV);
  localparam logic [CODE_W-1:0] COLD_HI = CODE_W'(COLD_MV);
  localparam logic [CODE_W-1:0] COLD_LO = CODE_W'(COLD_MV - COLD_HYS_MV);
  localparam logic [CODE_W-1:0] ONLY_HI = CODE_W'(ONLY_MV);
  localparam logic [CODE_W-1:0] ONLY_LO = CODE_W'(ONLY_MV - ONLY_HYS_MV);

  logic in_dis, in_only, in_hot, in_cold;

  // Each boundary uses the far threshold while its zone is the committed one.
  always_comb begin
    in_dis  = (zone_i == ZN_DIS)  ? (mv_i < EN_HI)   : (mv_i < EN_LO);
    in_only = (zone_i == ZN_ONLY) ? (mv_i > ONLY_LO) : (mv_i > ONLY_HI);
    in_hot  = (zone_i == ZN_HOT)  ? (mv_i < HOT_HI)  : (mv_i < HOT_LO);
    in_cold = (zone_i == ZN_COLD) ? (mv_i > COLD_LO) : (mv_i > COLD_HI);
    if (in_dis)       cand_o = ZN_DIS;
    else if (in_only) cand_o = ZN_ONLY;
    else if (in_hot)  cand_o = ZN_HOT;
    else if (in_cold) cand_o = ZN_COLD;
    else              cand_o = ZN_NORM;
  end
endmodule

// File: rtl/ts_zone_deglitch.sv
module ts_zone_deglitch
  import ts_zone_pkg::*;
#(
  parameter int TEMP_DGL_MS = 30,
  parameter int MODE_DGL_MS = 30
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  zone_t cand_i,
  output zone_t zone_o,
  output logic  new_cycle_o
);
  localparam int MAX_DGL = (TEMP_DGL_MS > MODE_DGL_MS) ? TEMP_DGL_MS : MODE_DGL_MS;
  localparam int CNT_W   = $clog2(MAX_DGL + 1) + 1;

  zone_t             zone_q, tgt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pulse_q;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  cnt_nxt;

  always_comb begin
    limit   = ((tgt_q == ZN_ONLY) || (zone_q == ZN_ONLY)) ? CNT_W'(MODE_DGL_MS)
                                                           : CNT_W'(TEMP_DGL_MS);
    cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zone_q  <= ZN_DIS;
      tgt_q   <= ZN_DIS;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (cand_i == zone_q) begin
        tgt_q <= zone_q;
        cnt_q <= '0;
      end else if (cand_i != tgt_q) begin
        tgt_q <= cand_i;
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_nxt >= limit) begin
          zone_q  <= tgt_q;
          cnt_q   <= '0;
          pulse_q <= (zone_q == ZN_DIS) || (zone_q == ZN_ONLY);
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end

  assign zone_o      = zone_q;
  assign new_cycle_o = pulse_q;

  // R6
  zone_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zone_q != $past(zone_q)) |-> $past(tick_i));

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R8
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (($past(zone_q) == ZN_DIS) || ($past(zone_q) == ZN_ONLY))
                && (zone_q != $past(zone_q)));
endmodule

// File: rtl/ts_zone_outputs.sv
module ts_zone_outputs
  import ts_zone_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int FOLD_MV = 1475
) (
  input  zone_t             zone_i,
  input  logic [CODE_W-1:0] mv_i,
  output logic              chg_en_o,
  output logic              tmr_hold_o,
  output logic              term_dis_o,
  output bias_t             bias_o
);
  localparam logic [CODE_W-1:0] FOLD_TH = CODE_W'(FOLD_MV);

  always_comb begin
    chg_en_o   = (zone_i == ZN_NORM) || (zone_i == ZN_ONLY);
    tmr_hold_o = (zone_i == ZN_ONLY);
    term_dis_o = (zone_i == ZN_ONLY);
    if (zone_i == ZN_DIS)      bias_o = BS_DIS;
    else if (mv_i >= FOLD_TH)  bias_o = BS_FOLD;
    else                       bias_o = BS_NORM;
  end
endmodule

// File: rtl/ts_zone_monitor.sv
module ts_zone_monitor
  import ts_zone_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int EN_MV       = 88,
  parameter int EN_HYS_MV   = 12,
  parameter int HOT_MV      = 275,
  parameter int HOT_HYS_MV  = 20,
  parameter int COLD_MV     = 1250,
  parameter int COLD_HYS_MV = 100,
  parameter int ONLY_MV     = 1600,
  parameter int ONLY_HYS_MV = 100,
  parameter int FOLD_MV     = 1475,
  parameter int TEMP_DGL_MS = 30,
  parameter int MODE_DGL_MS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1ms,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [CODE_W-1:0] smp_mv,
  output logic [2:0]        zone_o,
  output logic              chg_en_o,
  output logic              tmr_hold_o,
  output logic              term_dis_o,
  output logic              new_cycle_o,
  output logic [1:0]        bias_sel_o
);
  logic [CODE_W-1:0] mv_q;
  zone_t             zone, cand;
  bias_t             bias;

  assign smp_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mv_q <= '0;
    else if (smp_valid) mv_q <= smp_mv;
  end

  ts_zone_classify #(
    .CODE_W(CODE_W), .EN_MV(EN_MV), .EN_HYS_MV(EN_HYS_MV),
    .HOT_MV(HOT_MV), .HOT_HYS_MV(HOT_HYS_MV),
    .COLD_MV(COLD_MV), .COLD_HYS_MV(COLD_HYS_MV),
    .ONLY_MV(ONLY_MV), .ONLY_HYS_MV(ONLY_HYS_MV)
  ) classify_i (
    .zone_i(zone), .mv_i(mv_q), .cand_o(cand)
  );

  ts_zone_deglitch #(
    .TEMP_DGL_MS(TEMP_DGL_MS), .MODE_DGL_MS(MODE_DGL_MS)
  ) deglitch_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_1ms), .cand_i(cand),
    .zone_o(zone), .new_cycle_o(new_cycle_o)
  );

  ts_zone_outputs #(
    .CODE_W(CODE_W), .FOLD_MV(FOLD_MV)
  ) outputs_i (
    .zone_i(zone), .mv_i(mv_q), .chg_en_o(chg_en_o),
    .tmr_hold_o(tmr_hold_o), .term_dis_o(term_dis_o), .bias_o(bias)
  );

  assign zone_o     = zone;
  assign bias_sel_o = bias;

  // R10
  hold_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(mv_q));

  // R7
  hold_term_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_hold_o |-> (term_dis_o && chg_en_o));

  // R9
  dis_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_sel_o == 2'd2) |-> !chg_en_o);
endmodule

// File: tb/ts_zone_monitor_tb_top.sv
module ts_zone_monitor_tb_top;
  localparam int CLK_PER = 10;
  localparam int DGL     = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1ms = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [11:0] smp_mv = '0;
  logic [2:0]  zone_o;
  logic        chg_en_o, tmr_hold_o, term_dis_o, new_cycle_o;
  logic [1:0]  bias_sel_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_zone = 0, m_tgt = 0, m_cnt = 0, m_mv = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  ts_zone_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_mv(smp_mv), .zone_o(zone_o),
    .chg_en_o(chg_en_o), .tmr_hold_o(tmr_hold_o), .term_dis_o(term_dis_o),
    .new_cycle_o(new_cycle_o), .bias_sel_o(bias_sel_o)
  );

  function automatic int cand_of(input int z, input int v);
    bit d, o, h, c;
    d = (z == 0) ? (v < 88)   : (v < 76);
    o = (z == 4) ? (v > 1500) : (v > 1600);
    h = (z == 1) ? (v < 295)  : (v < 275);
    c = (z == 3) ? (v > 1150) : (v > 1250);
    if (d) return 0;
    if (o) return 4;
    if (h) return 1;
    if (c) return 3;
    return 2;
  endfunction

  function automatic int exp_bias(input int z, input int v);
    if (z == 0) return 2;
    return (v >= 1475) ? 1 : 0;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_outs(input string tag);
    chk(int'(chg_en_o),   (m_zone == 2 || m_zone == 4) ? 1 : 0, {"R7 chg_en ", tag});
    chk(int'(tmr_hold_o), (m_zone == 4) ? 1 : 0, {"R7 tmr_hold ", tag});
    chk(int'(term_dis_o), (m_zone == 4) ? 1 : 0, {"R7 term_dis ", tag});
    chk(int'(bias_sel_o), exp_bias(m_zone, m_mv), {"R9 bias ", tag});
  endtask

  task automatic do_tick();
    int old, c;
    old = m_zone;
    c = cand_of(m_zone, m_mv);
    if (c == m_zone) begin
      m_tgt = m_zone; m_cnt = 0;
    end else begin
      if (c != m_tgt) begin m_tgt = c; m_cnt = 0; end
      m_cnt++;
      if (m_cnt >= DGL) begin m_zone = c; m_cnt = 0; end
    end
    tick_1ms = 1'b1;
    @(negedge clk);
    tick_1ms = 1'b0;
    chk(int'(zone_o), m_zone, "R6 zone after tick");
    chk(int'(new_cycle_o), (old != m_zone && (old == 0 || old == 4)) ? 1 : 0,
        "R8 new_cycle on commit");
    chk_outs("after tick");
    @(negedge clk);
    chk(int'(new_cycle_o), 0, "R8 new_cycle one clock");
    @(negedge clk);
  endtask

  task automatic apply(input int v, input int n);
    @(negedge clk);
    smp_mv = 12'(v); smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; m_mv = v;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int'(zone_o), 0, "R1 zone");
    chk(int'(chg_en_o), 0, "R1 chg_en");
    chk(int'(tmr_hold_o), 0, "R1 tmr_hold");
    chk(int'(term_dis_o), 0, "R1 term_dis");
    chk(int'(new_cycle_o), 0, "R1 new_cycle");
    chk(int'(bias_sel_o), 2, "R1 bias");
    chk(int'(smp_ready), 1, "R1 ready");
    rst_n = 1'b1;
    @(negedge clk);

    // R6 exact count: 29 ticks keep zone, 30th commits
    apply(500, DGL - 1);
    chk(int'(zone_o), 0, "R6 no commit before N ticks");
    do_tick();
    chk(int'(zone_o), 2, "R6 commit on Nth tick");

    // R2 disable boundary and its hysteresis
    apply(80, 40);  chk(int'(zone_o), 1, "R2 76 mV floor not crossed");
    apply(75, 40);  chk(int'(zone_o), 0, "R2 below 76 mV disables");
    apply(87, 40);  chk(int'(zone_o), 0, "R2 87 mV stays disabled");
    apply(88, 40);  chk(int'(zone_o), 1, "R2 88 mV leaves disabled");

    // R3 hot boundary
    apply(294, 40); chk(int'(zone_o), 1, "R3 294 mV stays hot");
    apply(295, 40); chk(int'(zone_o), 2, "R3 295 mV back to normal");
    apply(275, 40); chk(int'(zone_o), 2, "R3 275 mV still normal");
    apply(274, 40); chk(int'(zone_o), 1, "R3 274 mV hot");
    apply(400, 40);

    // R4 cold boundary
    apply(1250, 40); chk(int'(zone_o), 2, "R4 1250 mV still normal");
    apply(1251, 40); chk(int'(zone_o), 3, "R4 1251 mV cold");
    apply(1151, 40); chk(int'(zone_o), 3, "R4 1151 mV stays cold");
    apply(1150, 40); chk(int'(zone_o), 2, "R4 1150 mV normal");

    // R5 charger-only boundary
    apply(1600, 40); chk(int'(zone_o), 3, "R5 1600 mV is cold");
    apply(1601, 40); chk(int'(zone_o), 4, "R5 1601 mV charger-only");
    apply(1501, 40); chk(int'(zone_o), 4, "R5 1501 mV stays charger-only");
    apply(1500, 40); chk(int'(zone_o), 3, "R5 1500 mV leaves charger-only");

    // R6 interrupted deglitch is ignored
    apply(1700, 20);
    apply(1300, 40); chk(int'(zone_o), 3, "R6 short excursion ignored");

    // R10 code without valid has no effect
    @(negedge clk);
    smp_mv = 12'd1480; smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(int'(bias_sel_o), 0, "R10 ignored code keeps bias");
    do_tick();
    chk(int'(zone_o), 3, "R10 ignored code keeps zone");

    // R9 fold-back at 1475 mV
    apply(1475, 2); chk(int'(bias_sel_o), 1, "R9 fold at 1475 mV");
    apply(1474, 2); chk(int'(bias_sel_o), 0, "R9 normal at 1474 mV");

    // random phase
    for (int k = 0; k < 70; k++) begin
      int v, n, sel;
      int edges[12] = '{75, 76, 87, 88, 274, 275, 295, 1150, 1251, 1475, 1500, 1601};
      sel = $urandom_range(0, 2);
      v = (sel == 0) ? edges[$urandom_range(0, 11)] : $urandom_range(0, 2000);
      n = $urandom_range(1, 45);
      apply(v, n);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule